// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a hardware master for the two-wire serial management interface of an Ethernet PHY. It produces the management clock (MDC) and drives or releases the bidirectional data line (MDIO) to carry out one register read or one register write at a time. A caller sets the read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data, then pulses `start`. The block raises `busy` for the whole frame and pulses `done` for one cycle at the end. After a read, the 16-bit result is presented on `rdData`.

Every frame opens with a long preamble of 40 ones. A start pattern and the opcode follow, then the two addresses, a turnaround and the 16 data bits. A read releases the line before its turnaround slot. Both kinds of frame end with one extra clock pulse while the line is released. Each MDC half-period lasts `HALF_DIV+1` system clocks. The pin side is split into output, output-enable and input, so an I/O cell outside the block makes up the tri-state pad.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is in progress, `mdc` is low, `mdioOe` is low and `busy` is low.
- R2: A frame begins with `mdioOe` high and 40 consecutive MDC rising edges on which `mdioOut` is 1.
- R3: Rising edges 41 and 42 carry 0 then 1 (start). Edges 43 and 44 carry the opcode: 1,0 for a read (`wrSel`=0) and 0,1 for a write (`wrSel`=1).
- R4: Edges 45 to 49 carry `phyAddr` MSB first. Edges 50 to 54 carry `regAddr` MSB first.
- R5: A write drives 1 then 0 on edges 55 and 56 and `wrData` MSB first on edges 57 to 72. It then releases `mdioOe` and gives one more MDC pulse, for 73 rising edges in total.
- R6: A read releases `mdioOe` from edge 55 to the end of the frame: one turnaround pulse, 16 data pulses and one final pulse, for 72 rising edges in total.
- R7: During a read, `mdioIn` is captured at the end of each MDC high phase for edges 56 to 71. The bits shift in MSB first, so `rdData` holds the 16 bits in that order.
- R8: Inside a frame, every MDC high phase and every MDC low phase lasts exactly `HALF_DIV+1` clock cycles.
- R9: `busy` rises on the clock edge that accepts `start` and falls on the edge where `done` is high. `done` lasts exactly one cycle, and `rdData` holds the read result while `done` is high.
- R10: A `start` while `busy` is high is ignored: the frame in progress continues unchanged, and there is only one `done`.
- R11: `mdioOut` and `mdioOe` change only while MDC is low, and they are stable across each MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction when idle |
| wrSel | input | 1 | 1 = write, 0 = read |
| phyAddr | input | 5 | PHY address |
| regAddr | input | 5 | Register address |
| wrData | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdData | output | 16 | Read result |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line output value |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line input value |

## Verification
The bench builds the block with `HALF_DIV` = 2, so each half-period is three system clocks. The divider counter then passes through a middle value, not only wrapping straight from zero to its limit. Because of this, a miscounted half-period or a data change that lands inside a high phase shows up as a wrong run length at the pins. A PHY model in the bench drives the read bits one MDC edge at a time. This makes a sample taken one slot early or late visible in `rdData`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 40;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  // preamble + start(2) + opcode(2) + two addresses + turnaround(2) + data
  localparam int FRAME_W   = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int HDR_SLOTS = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int WR_SLOTS  = FRAME_W + 1;
  localparam int RD_FIRST  = HDR_SLOTS + 1;
  localparam int RD_LAST   = RD_FIRST + DATA_W - 1;
  localparam int RD_SLOTS  = RD_LAST + 2;
  localparam int SLOT_W    = $clog2(WR_SLOTS + 1);

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
  } dpStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       wrSel,
  output logic       busy,
  output logic       done,
  output logic       mdc,
  output logic       mdioOe,
  output dpStrobes_t strobes
);
  localparam int CNT_W = (HALF_DIV < 1) ? 1 : $clog2(HALF_DIV + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_DIV);

  logic              running;
  logic              isWrite;
  logic              phaseHigh;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] lastSlot;
  logic [SLOT_W-1:0] drivenSlots;
  logic              slotEnd;

  assign lastSlot    = isWrite ? SLOT_W'(WR_SLOTS - 1) : SLOT_W'(RD_SLOTS - 1);
  assign drivenSlots = isWrite ? SLOT_W'(FRAME_W) : SLOT_W'(HDR_SLOTS);
  assign slotEnd     = running && phaseHigh && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      isWrite   <= 1'b0;
      phaseHigh <= 1'b0;
      cnt       <= '0;
      slot      <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!running) begin
        if (start) begin
          running   <= 1'b1;
          isWrite   <= wrSel;
          phaseHigh <= 1'b0;
          cnt       <= '0;
          slot      <= '0;
        end
      end else if (cnt == CNT_MAX) begin
        cnt <= '0;
        if (!phaseHigh) begin
          phaseHigh <= 1'b1;
        end else begin
          phaseHigh <= 1'b0;
          if (slot == lastSlot) begin
            running <= 1'b0;
            done    <= 1'b1;
          end else begin
            slot <= slot + 1'b1;
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.load   = !running && start;
    strobes.shift  = slotEnd;
    strobes.sample = slotEnd && !isWrite &&
                     (slot >= SLOT_W'(RD_FIRST)) && (slot <= SLOT_W'(RD_LAST));
  end

  assign busy   = running;
  assign mdc    = running && phaseHigh;
  assign mdioOe = running && (slot < drivenSlots);
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dpStrobes_t        strobes,
  input  logic              wrSel,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic [DATA_W-1:0] rdData
);
  logic [FRAME_W-1:0] frameReg;
  logic [FRAME_W-1:0] frameNext;

  always_comb begin
    if (wrSel)
      frameNext = {{PRE_LEN{1'b1}}, 2'b01, 2'b01, phyAddr, regAddr, 2'b10, wrData};
    else
      frameNext = {{PRE_LEN{1'b1}}, 2'b01, 2'b10, phyAddr, regAddr, {(DATA_W + 2){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frameReg <= '0;
      rdData   <= '0;
    end else begin
      if (strobes.load)
        frameReg <= frameNext;
      else if (strobes.shift)
        frameReg <= {frameReg[FRAME_W-2:0], 1'b0};
      if (strobes.sample)
        rdData <= {rdData[DATA_W-2:0], mdioIn};
    end
  end

  assign mdioOut = frameReg[FRAME_W-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        wrSel,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  dpStrobes_t strobes;

  mdio_ctrl #(.HALF_DIV(HALF_DIV)) uCtrl (
    .clk(clk), .rst(rst), .start(start), .wrSel(wrSel),
    .busy(busy), .done(done), .mdc(mdc), .mdioOe(mdioOe), .strobes(strobes)
  );

  mdio_datapath uData (
    .clk(clk), .rst(rst), .strobes(strobes), .wrSel(wrSel),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .rdData(rdData)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe
);
  int hiRun;
  int loRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiRun <= 0;
      loRun <= 0;
    end else begin
      hiRun <= mdc ? hiRun + 1 : 0;
      loRun <= (busy && !mdc) ? loRun + 1 : 0;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdioOe));

  a_r11_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> ($stable(mdioOut) && $stable(mdioOe)));

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r8_high_len: assert property (@(posedge clk) disable iff (rst)
    $fell(mdc) |-> (hiRun == HALF_DIV + 1));

  a_r8_low_len: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> (loRun == HALF_DIV + 1));
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) uChk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        wrSel;
  logic [4:0]  phyAddr;
  logic [4:0]  regAddr;
  logic [15:0] wrData;
  logic        busy;
  logic        done;
  logic [15:0] rdData;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  mdio_master #(.HALF_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .start(start), .wrSel(wrSel),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData),
    .busy(busy), .done(done), .rdData(rdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // bench-side monitor and PHY model, sampled at negedge
  logic        bits [0:79];
  logic        oes  [0:79];
  int          riseCnt;
  int          stabErr;
  int          lenErr;
  int          hiRun;
  int          loRun;
  int          doneCnt;
  logic [15:0] rdAtDone;
  logic        busyAtDone;
  logic [15:0] phyVal;
  logic        prevMdc;
  logic        prevOut;
  logic        prevOe;

  always @(negedge clk) begin
    if (done) begin
      doneCnt++;
      rdAtDone   = rdData;
      busyAtDone = busy;
    end
    if (mdc && !prevMdc) begin
      if (riseCnt < 80) begin
        bits[riseCnt] = mdioOut;
        oes[riseCnt]  = mdioOe;
      end
      if (mdioOut !== prevOut || mdioOe !== prevOe) stabErr++;
      if (loRun != DIV + 1) lenErr++;
      loRun = 0;
      if (riseCnt >= 55 && riseCnt <= 70) mdioIn = phyVal[70 - riseCnt];
      riseCnt++;
    end
    if (!mdc && prevMdc) begin
      if (hiRun != DIV + 1) lenErr++;
      hiRun = 0;
    end
    if (mdc) hiRun++;
    if (busy && !mdc) loRun++;
    prevMdc = mdc;
    prevOut = mdioOut;
    prevOe  = mdioOe;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic expBit(input int s, input bit w, input logic [4:0] pa,
                                  input logic [4:0] ra, input logic [15:0] d);
    if (s < 40) return 1'b1;
    if (s == 40) return 1'b0;
    if (s == 41) return 1'b1;
    if (s == 42) return !w;
    if (s == 43) return w;
    if (s <= 48) return pa[48 - s];
    if (s <= 53) return ra[53 - s];
    if (s == 54) return 1'b1;
    if (s == 55) return 1'b0;
    return d[71 - s];
  endfunction

  task automatic clearMon();
    riseCnt = 0; stabErr = 0; lenErr = 0; hiRun = 0; loRun = 0; doneCnt = 0;
  endtask

  task automatic pulseStart(input bit w, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [15:0] d);
    @(negedge clk);
    wrSel = w; phyAddr = pa; regAddr = ra; wrData = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
    check(n < 5000, "R9", "frame finished before timeout", n, 5000);
  endtask

  task automatic checkFrame(input bit w, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [15:0] d);
    int errPre = 0, errHdr = 0, errAddr = 0, errTail = 0, errOe = 0;
    int total = w ? 73 : 72;
    int driven = w ? 72 : 54;
    for (int s = 0; s < 40; s++) if (bits[s] !== 1'b1) errPre++;
    for (int s = 40; s < 44; s++) if (bits[s] !== expBit(s, w, pa, ra, d)) errHdr++;
    for (int s = 44; s < 54; s++) if (bits[s] !== expBit(s, w, pa, ra, d)) errAddr++;
    if (w) for (int s = 54; s < 72; s++) if (bits[s] !== expBit(s, w, pa, ra, d)) errTail++;
    for (int s = 0; s < total; s++) if (oes[s] !== (s < driven)) errOe++;
    check(errPre == 0, "R2", "preamble ones", errPre, 0);
    check(errHdr == 0, "R3", "start and opcode", errHdr, 0);
    check(errAddr == 0, "R4", "address bits", errAddr, 0);
    check(riseCnt == total, w ? "R5" : "R6", "rising edge count", riseCnt, total);
    check(errOe == 0, w ? "R5" : "R6", "output enable pattern", errOe, 0);
    if (w) check(errTail == 0, "R5", "turnaround and data", errTail, 0);
    check(lenErr == 0, "R8", "half-period length errors", lenErr, 0);
    check(stabErr == 0, "R11", "changes across rising edge", stabErr, 0);
    check(doneCnt == 1, "R9", "done pulse count", doneCnt, 1);
    check(busyAtDone == 1'b0, "R9", "busy low with done", busyAtDone, 0);
    check(!mdc && !mdioOe, "R1", "idle after frame", {mdc, mdioOe}, 0);
  endtask

  task automatic testReset();
    check(!busy && !mdc && !mdioOe && !done, "R1", "reset state",
          {busy, mdc, mdioOe, done}, 0);
  endtask

  task automatic testWrite(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    clearMon();
    pulseStart(1'b1, pa, ra, d);
    check(busy === 1'b1, "R9", "busy after start", busy, 1);
    waitIdle();
    checkFrame(1'b1, pa, ra, d);
  endtask

  task automatic testRead(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] v);
    clearMon();
    phyVal = v;
    pulseStart(1'b0, pa, ra, 16'h0);
    waitIdle();
    checkFrame(1'b0, pa, ra, 16'h0);
    check(rdAtDone === v, "R7", "read data at done", rdAtDone, v);
  endtask

  task automatic testStartWhileBusy();
    clearMon();
    phyVal = 16'h3C5A;
    pulseStart(1'b0, 5'h0A, 5'h15, 16'h0);
    repeat (100) @(negedge clk);
    pulseStart(1'b1, 5'h1F, 5'h00, 16'hFFFF);
    waitIdle();
    check(riseCnt == 72, "R10", "frame length kept", riseCnt, 72);
    check(doneCnt == 1, "R10", "single done", doneCnt, 1);
    check(bits[43] === 1'b0 && bits[44] === 1'b0, "R10", "original address kept",
          {bits[43], bits[44]}, 0);
    check(rdAtDone === 16'h3C5A, "R10", "read result kept", rdAtDone, 16'h3C5A);
  endtask

  initial begin
    bit timedOut = 1'b0;
    rst = 1'b1; start = 1'b0; wrSel = 1'b0; phyAddr = '0; regAddr = '0;
    wrData = '0; mdioIn = 1'b0; phyVal = '0; busyAtDone = 1'b1; rdAtDone = '0;
    prevMdc = 1'b0; prevOut = 1'b0; prevOe = 1'b0;
    clearMon();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    fork
      begin
        testReset();
        testWrite(5'h11, 5'h0A, 16'hA55A);
        testWrite(5'h00, 5'h1F, 16'h0001);
        testRead(5'h1F, 5'h00, 16'h8001);
        testRead(5'h05, 5'h12, 16'h7E3C);
        testStartWhileBusy();
      end
      begin
        repeat (100000) @(negedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) check(1'b0, "R9", "watchdog expired", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule